// File: doc/BRIEF.md
# Read-Sequence Unlock Detector

This block watches the access stream of a memory port and recognises a secret key made of six back-to-back reads. The first five reads of the key are shared. The address of the sixth read chooses the result: a store command, a recall command, or a reserved test pattern that raises only a flag. When the key completes, the block issues a single-cycle request to the nonvolatile transfer controller and returns to idle.

The block only listens. Every access still reaches the memory as usual. Accesses arrive already decoded as one strobe per access, with a write qualifier. Output-enable plays no part in recognition, so the block has no such input. Any access that does not continue the key breaks it, and that includes a write or a repeated strobe caused by noise. While the controller reports busy, strobes are disregarded and the progress made so far is kept.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `test_flag` are low and the detector is idle, so zero key steps have been matched.
- R2: Only address bits [13:0] are compared. Bit 14 and any higher bits do not affect matching. The five shared key reads are, in order, 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F.
- R3: A sixth read at 0x0FC0, directly after the five shared reads, drives `store_req` high for exactly one cycle. The pulse appears in the cycle after the clock edge that samples that strobe.
- R4: A sixth read at 0x0C63 in the same position drives `recall_req` high for exactly one cycle, with the same timing as R3.
- R5: A sixth read at 0x339C in the same position drives `test_flag` high for one cycle and raises neither `store_req` nor `recall_req`.
- R6: A strobe with `acc_write`=1 at any step returns the detector to idle, even when its address matches the expected key step. No request follows.
- R7: A read whose address is not the expected one breaks the key. If that read equals the first key address 0x0E38, it counts as step one of a new attempt. Otherwise the detector goes idle. This applies to the sixth position as well.
- R8: A repeated strobe on the same address counts as a separate access and breaks the key.
- R9: While `ctrl_busy` is high, strobes change nothing and raise no output. Progress made before the busy period is kept.
- R10: After any sixth-step result, the detector is idle. A lone sixth address, or the key with its first read missing, fires nothing.
- R11: At most one of the three outputs is high in any cycle, and none stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_strobe | input | 1 | One-cycle pulse for each access |
| acc_addr | input | ADDR_W (15) | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| ctrl_busy | input | 1 | Transfer controller busy; strobes are ignored while high |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |
| test_flag | output | 1 | One-cycle reserved-pattern flag |

## Verification
The assertions check, on every cycle, that the three outputs are mutually exclusive single pulses. They also check that no output follows a write strobe or a strobe taken while busy, and that any result leaves the step counter at zero after it had reached the last step. The bench's scenarios supply what no property can state: that only the exact key order fires, that bit 14 is ignored, that a break on 0x0E38 restarts at step one, and that a noisy repeated strobe or a busy gap acts as the requirements say. A behavioural model is compared against all three outputs on every clock.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  localparam int CMP_W = 14;
  localparam int N_PRE = 5;

  typedef logic [CMP_W-1:0] key_t;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_STORE  = 2'd1,
    HIT_RECALL = 2'd2,
    HIT_TEST   = 2'd3
  } hit_e;

  localparam key_t KEY_STORE  = 14'h0FC0;
  localparam key_t KEY_RECALL = 14'h0C63;
  localparam key_t KEY_TEST   = 14'h339C;

  // Shared prefix of the key; its order is the required access order.
  function automatic key_t prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction

endpackage

// File: rtl/cmd_seq_match.sv
module cmd_seq_match
  import cmd_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [CMP_W-1:0]  addr_cmp,
  input  logic [STEP_W-1:0] step,
  output logic              step_hit,
  output logic              first_hit,
  output hit_e              final_hit
);

  logic [N_PRE-1:0] pre_eq;

  genvar gi;
  generate
    for (gi = 0; gi < N_PRE; gi++) begin : g_pre
      assign pre_eq[gi] = (addr_cmp == prefix_key(gi));
    end
  endgenerate

  assign first_hit = pre_eq[0];

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < N_PRE; i++) begin
      if (step == STEP_W'(i)) step_hit = pre_eq[i];
    end
  end

  always_comb begin
    if (addr_cmp == KEY_STORE)       final_hit = HIT_STORE;
    else if (addr_cmp == KEY_RECALL) final_hit = HIT_RECALL;
    else if (addr_cmp == KEY_TEST)   final_hit = HIT_TEST;
    else                             final_hit = HIT_NONE;
  end

endmodule

// File: rtl/cmd_seq_step.sv
module cmd_seq_step
  import cmd_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_take,
  input  logic              acc_write,
  input  logic              step_hit,
  input  logic              first_hit,
  input  hit_e              final_hit,
  output logic [STEP_W-1:0] step,
  output hit_e              fire
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_PRE);

  logic [STEP_W-1:0] step_n;
  hit_e              fire_n;

  always_comb begin
    step_n = step;
    fire_n = HIT_NONE;
    if (acc_take) begin
      if (acc_write) begin
        step_n = '0;
      end else if (step == LAST) begin
        fire_n = final_hit;
        if (final_hit != HIT_NONE) step_n = '0;
        else                       step_n = first_hit ? STEP_W'(1) : '0;
      end else if (step_hit) begin
        step_n = step + STEP_W'(1);
      end else begin
        step_n = first_hit ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      fire <= HIT_NONE;
    end else begin
      step <= step_n;
      fire <= fire_n;
    end
  end

  // R10: a result leaves the counter idle, and only the last step produces one
  p_fire_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != HIT_NONE) |-> (step == '0) && ($past(step) == LAST));

  // R1: counter never exceeds the last step
  p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);

endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              ctrl_busy,
  output logic              store_req,
  output logic              recall_req,
  output logic              test_flag
);

  localparam int STEP_W = $clog2(N_PRE + 1);

  logic [CMP_W-1:0]  addr_cmp;
  logic              acc_take;
  logic              step_hit;
  logic              first_hit;
  hit_e              final_hit;
  logic [STEP_W-1:0] step;
  hit_e              fire;

  assign addr_cmp = acc_addr[CMP_W-1:0];
  assign acc_take = acc_strobe & ~ctrl_busy;

  cmd_seq_match #(.STEP_W(STEP_W)) i_match (
    .addr_cmp  (addr_cmp),
    .step      (step),
    .step_hit  (step_hit),
    .first_hit (first_hit),
    .final_hit (final_hit)
  );

  cmd_seq_step #(.STEP_W(STEP_W)) i_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_take  (acc_take),
    .acc_write (acc_write),
    .step_hit  (step_hit),
    .first_hit (first_hit),
    .final_hit (final_hit),
    .step      (step),
    .fire      (fire)
  );

  assign store_req  = (fire == HIT_STORE);
  assign recall_req = (fire == HIT_RECALL);
  assign test_flag  = (fire == HIT_TEST);

  // R11: outputs exclusive
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req, test_flag}));

  // R3: store is a single pulse
  p_store_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  // R4: recall is a single pulse
  p_recall_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);

  // R5: test flag is a single pulse
  p_test_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_flag |=> !test_flag);

  // R6: a write strobe never yields a result
  p_write_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !ctrl_busy && acc_write) |=> !(store_req || recall_req || test_flag));

  // R9: nothing results from a cycle spent busy
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy |=> !(store_req || recall_req || test_flag));

endmodule

// File: tb/test_cmd_seq_detect.sv
module test_cmd_seq_detect;

  logic        clk;
  logic        rst_n;
  logic        acc_strobe;
  logic [14:0] acc_addr;
  logic        acc_write;
  logic        ctrl_busy;
  logic        store_req;
  logic        recall_req;
  logic        test_flag;

  int checks   = 0;
  int failures = 0;
  int n_store  = 0;
  int n_recall = 0;
  int n_test   = 0;
  bit done     = 0;

  int key[5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

  // reference model state
  int m_step = 0;
  bit e_store, e_recall, e_test;

  cmd_seq_detect i_cmd_seq_detect (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_write(acc_write), .ctrl_busy(ctrl_busy), .store_req(store_req),
    .recall_req(recall_req), .test_flag(test_flag)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; e_store = 0; e_recall = 0; e_test = 0;
    end else begin
      int a;
      a = int'(acc_addr[13:0]);
      e_store = 0; e_recall = 0; e_test = 0;
      if (acc_strobe && !ctrl_busy) begin
        if (acc_write) m_step = 0;
        else if (m_step == 5) begin
          if (a == 'h0FC0) begin e_store = 1; m_step = 0; end
          else if (a == 'h0C63) begin e_recall = 1; m_step = 0; end
          else if (a == 'h339C) begin e_test = 1; m_step = 0; end
          else m_step = (a == key[0]) ? 1 : 0;
        end else if (a == key[m_step]) m_step = m_step + 1;
        else m_step = (a == key[0]) ? 1 : 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R3 R4 R5 R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(store_req == e_store,   "R3 store_req vs model",  store_req,  e_store);
      check(recall_req == e_recall, "R4 recall_req vs model", recall_req, e_recall);
      check(test_flag == e_test,    "R5 test_flag vs model",  test_flag,  e_test);
      check($countones({store_req, recall_req, test_flag}) <= 1, "R11 exclusive",
            $countones({store_req, recall_req, test_flag}), 1);
      if (store_req)  n_store++;
      if (recall_req) n_recall++;
      if (test_flag)  n_test++;
    end
  end

  task automatic acc(input int a, input bit w);
    @(negedge clk);
    acc_strobe = 1; acc_addr = 15'(a); acc_write = w;
    @(negedge clk);
    acc_strobe = 0; acc_write = 0;
  endtask

  task automatic prefix(input int hi);
    for (int i = 0; i < 5; i++) acc(key[i] | hi, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_counts(input string tag, input int s, input int r, input int t);
    idle(2);
    check(n_store == s,  {tag, " store count"},  n_store,  s);
    check(n_recall == r, {tag, " recall count"}, n_recall, r);
    check(n_test == t,   {tag, " test count"},   n_test,   t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; acc_strobe = 0; acc_addr = '0; acc_write = 0; ctrl_busy = 0;
    repeat (3) @(negedge clk);
    check({store_req, recall_req, test_flag} == 3'b000, "R1 outputs in reset",
          {store_req, recall_req, test_flag}, 0);
    rst_n = 1;
    idle(2);
    check({store_req, recall_req, test_flag} == 3'b000, "R1 outputs after reset",
          {store_req, recall_req, test_flag}, 0);

    prefix(0); acc('h0FC0, 0);
    expect_counts("R3", 1, 0, 0);
    prefix(0); acc('h0C63, 0);
    expect_counts("R4", 1, 1, 0);
    prefix(0); acc('h339C, 0);
    expect_counts("R5", 1, 1, 1);

    prefix('h4000); acc('h4FC0, 0);
    expect_counts("R2 bit14 ignored", 2, 1, 1);

    acc(key[0], 0); acc(key[1], 0); acc(key[2], 1);
    acc(key[3], 0); acc(key[4], 0); acc('h0FC0, 0);
    expect_counts("R6 write aborts", 2, 1, 1);
    prefix(0); acc('h0FC0, 1);
    expect_counts("R6 write at sixth", 2, 1, 1);

    acc(key[0], 0); acc(key[1], 0); acc('h1234, 0);
    acc(key[2], 0); acc(key[3], 0); acc(key[4], 0); acc('h0C63, 0);
    expect_counts("R7 mismatch aborts", 2, 1, 1);
    acc(key[0], 0); acc(key[1], 0); acc(key[0], 0);
    acc(key[1], 0); acc(key[2], 0); acc(key[3], 0); acc(key[4], 0); acc('h0C63, 0);
    expect_counts("R7 reload step one", 2, 2, 1);
    prefix(0); acc('h1111, 0); acc(key[1], 0); acc(key[2], 0);
    acc(key[3], 0); acc(key[4], 0); acc('h0FC0, 0);
    expect_counts("R7 bad sixth", 2, 2, 1);
    prefix(0); acc(key[0], 0); acc(key[1], 0); acc(key[2], 0);
    acc(key[3], 0); acc(key[4], 0); acc('h0FC0, 0);
    expect_counts("R7 sixth is first key", 3, 2, 1);

    acc(key[0], 0); acc(key[1], 0); acc(key[1], 0);
    acc(key[2], 0); acc(key[3], 0); acc(key[4], 0); acc('h0FC0, 0);
    expect_counts("R8 repeated strobe", 3, 2, 1);

    acc(key[0], 0); acc(key[1], 0); acc(key[2], 0);
    ctrl_busy = 1;
    acc('h2222, 0); acc(key[0], 1); acc('h0FC0, 0);
    ctrl_busy = 0;
    acc(key[3], 0); acc(key[4], 0); acc('h0FC0, 0);
    expect_counts("R9 busy keeps progress", 4, 2, 1);
    prefix(0);
    ctrl_busy = 1; acc('h0FC0, 0); ctrl_busy = 0;
    expect_counts("R9 busy blocks sixth", 4, 2, 1);
    acc('h0FC0, 0);
    expect_counts("R9 sixth after busy", 5, 2, 1);

    acc('h0FC0, 0);
    expect_counts("R10 lone sixth", 5, 2, 1);
    for (int i = 1; i < 5; i++) acc(key[i], 0);
    acc('h0C63, 0);
    expect_counts("R10 missing first", 5, 2, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule